// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of virtual-to-physical page translations. Each slot holds a virtual page number, an 8-bit address-space identifier, a global flag, a physical page number and a valid bit. A lookup presents a virtual address and the current address-space identifier. One cycle later the block answers with a hit and the physical page number, a miss, or a fault when the address is not canonical.

Software fills the buffer through an insert port. The slot to overwrite is chosen by a rotating pointer, so no use history is kept per slot. A flush port removes translations in three ways: all of them, only the ones that are not global, or the ones that match a single page in one address space. A three-slot list of recently used slot indices is checked before the full array. It gives the same answer as the array and only shortens the path for pages in active use.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is 0, the recently-used list is empty and `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_ppn` are 0.
- R2: A lookup on `lk_valid` is answered on the next clock edge. `rsp_valid` is `lk_valid` delayed by one cycle.
- R3: A lookup hits only when a valid slot has the same virtual page number (`va[IMPL_W-1:PG_W]`) and either the same address-space identifier or its global flag set. A hit returns that slot's page number. A miss returns `rsp_hit`=0 and `rsp_ppn`=0.
- R4: An address is canonical only when bits `[VA_W-1:IMPL_W]` are all 0 or all 1. A lookup of any other address gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_ppn`=0, and leaves the recently-used list unchanged.
- R5: An insert always writes the slot under the replacement pointer, even if that slot is valid. The pointer then advances by one and wraps from N-1 to 0, so N+2 back-to-back inserts evict the first two.
- R6: Flush code 0 invalidates every slot.
- R7: Flush code 1 invalidates every slot whose global flag is clear and keeps the global ones.
- R8: Flush code 2 invalidates the slots that a lookup of `fl_va` with `fl_asn` would hit, global slots included.
- R9: Flush code 3 is reserved and has no effect. An insert in the same cycle goes ahead.
- R10: A flush with code 0 to 2 in the same cycle as an insert wins. The insert is dropped and the pointer does not move. Any such flush also empties the recently-used list.
- R11: A lookup in the same cycle as an insert or flush sees the contents from before that cycle.
- R12: When the recently-used list supplies a hit, that hit names a slot that the full array also hits. Repeated lookups therefore return the same result as the array alone. Each hit or insert pushes its slot index into position 0 and shifts the older ones down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Lookup address-space identifier |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Non-canonical address |
| rsp_ppn | output | PPN_W | Physical page number, 0 unless hit |
| ins_valid | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of the new translation |
| ins_asn | input | ASN_W | Address-space identifier of the new translation |
| ins_global | input | 1 | New translation matches every address space |
| ins_ppn | input | PPN_W | Physical page number of the new translation |
| fl_valid | input | 1 | Flush request |
| fl_op | input | 2 | Flush kind: 0 all, 1 non-global, 2 one page, 3 reserved |
| fl_va | input | VA_W | Page address for flush kind 2 |
| fl_asn | input | ASN_W | Address-space identifier for flush kind 2 |

## Verification
A wrong valid bit, tag or page number in one slot shows at the ports on the first lookup that reaches that slot: a false hit, a missed hit or a wrong page number, one cycle after the request. A replacement pointer that steps wrongly shows up only later, when a translation that should still be present misses, so the bench fills past capacity and then probes every key. A stale recently-used entry could return the page number of an overwritten or flushed slot, so the random phase repeats lookups of hot keys across inserts and flushes, and every answer is compared with a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_NONGLB  = 2'd1,
    FL_PAGE    = 2'd2,
    FL_RSVD    = 2'd3
  } flush_op_e;
endpackage

// File: rtl/tlb_canon.sv
module tlb_canon #(
  parameter int VA_W   = 24,
  parameter int IMPL_W = 16
) (
  input  logic [VA_W-1:0] va,
  output logic            ok
);
  localparam int UW = VA_W - IMPL_W;

  generate
    if (UW == 0) begin : g_full
      assign ok = 1'b1;
    end else begin : g_chk
      logic [UW-1:0] upper;
      assign upper = va[VA_W-1:IMPL_W];
      assign ok    = (upper == '0) || (upper == '1);
    end
  endgenerate
endmodule

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int N     = 8,
  parameter int VPN_W = 8,
  parameter int ASN_W = 8,
  parameter int PPN_W = 12,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic [N-1:0]     hit_vec,
  output logic [IW-1:0]    hit_idx,
  input  logic [IW-1:0]    rd_idx,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_glb,
  input  logic [PPN_W-1:0] ins_ppn,
  output logic [IW-1:0]    victim,
  input  logic             fl_all,
  input  logic             fl_nonglb,
  input  logic             fl_page,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn
);
  logic [N-1:0]     vld_q, vld_d, glb_q, fl_vec, wr_en;
  logic [VPN_W-1:0] vpn_q [N];
  logic [ASN_W-1:0] asn_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [IW-1:0]    ptr_q, ptr_d;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_slot
      assign hit_vec[gi] = vld_q[gi] && (vpn_q[gi] == lk_vpn) &&
                           (glb_q[gi] || (asn_q[gi] == lk_asn));
      assign fl_vec[gi]  = vld_q[gi] && (vpn_q[gi] == fl_vpn) &&
                           (glb_q[gi] || (asn_q[gi] == fl_asn));
      assign wr_en[gi]   = ins_en && (ptr_q == IW'(gi));
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign rd_ppn = ppn_q[rd_idx];
  assign victim = ptr_q;

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < N; i++) begin
      if (fl_all)                       vld_d[i] = 1'b0;
      else if (fl_nonglb && !glb_q[i])  vld_d[i] = 1'b0;
      else if (fl_page && fl_vec[i])    vld_d[i] = 1'b0;
      else if (wr_en[i])                vld_d[i] = 1'b1;
    end
    ptr_d = ptr_q;
    if (ins_en) ptr_d = (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_en[i]) begin
        vpn_q[i] <= ins_vpn;
        asn_q[i] <= ins_asn;
        glb_q[i] <= ins_glb;
        ppn_q[i] <= ins_ppn;
      end
    end
  end
endmodule

// File: rtl/tlb_mru.sv
module tlb_mru #(
  parameter int N     = 8,
  parameter int DEPTH = 3,
  localparam int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hit_vec,
  output logic          sc_hit,
  output logic [IW-1:0] sc_idx,
  input  logic          clr,
  input  logic          push,
  input  logic [IW-1:0] push_idx
);
  logic [IW-1:0]    idx_q [DEPTH];
  logic [IW-1:0]    idx_d [DEPTH];
  logic [DEPTH-1:0] sv_q, sv_d;

  always_comb begin
    sc_hit = 1'b0;
    sc_idx = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (sv_q[s] && hit_vec[idx_q[s]]) begin
        sc_hit = 1'b1;
        sc_idx = idx_q[s];
      end
    end
  end

  always_comb begin
    idx_d = idx_q;
    sv_d  = sv_q;
    if (clr) begin
      sv_d = '0;
    end else if (push) begin
      for (int s = DEPTH - 1; s >= 1; s--) begin
        idx_d[s] = idx_q[s-1];
        sv_d[s]  = sv_q[s-1];
      end
      idx_d[0] = push_idx;
      sv_d[0]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= '0;
      for (int s = 0; s < DEPTH; s++) idx_q[s] <= '0;
    end else begin
      sv_q <= sv_d;
      for (int s = 0; s < DEPTH; s++) idx_q[s] <= idx_d[s];
    end
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb #(
  parameter int N      = 8,
  parameter int VA_W   = 24,
  parameter int IMPL_W = 16,
  parameter int PG_W   = 8,
  parameter int ASN_W  = 8,
  parameter int PPN_W  = 12,
  parameter int DEPTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             ins_valid,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic             fl_valid,
  input  logic [1:0]       fl_op,
  input  logic [VA_W-1:0]  fl_va,
  input  logic [ASN_W-1:0] fl_asn
);
  localparam int VPN_W = IMPL_W - PG_W;
  localparam int IW    = $clog2(N);

  tlb_pkg::flush_op_e op;
  logic             va_ok, lk_go, fl_en, ins_go, use_hit;
  logic [N-1:0]     hit_vec;
  logic [IW-1:0]    arr_idx, sc_idx, rd_idx, victim;
  logic             sc_hit, push;
  logic [IW-1:0]    push_idx;
  logic [PPN_W-1:0] rd_ppn;
  logic             rv_d, rh_d, rf_d;
  logic [PPN_W-1:0] rp_d;

  assign op     = tlb_pkg::flush_op_e'(fl_op);
  assign fl_en  = fl_valid && (op != tlb_pkg::FL_RSVD);
  assign ins_go = ins_valid && !fl_en;

  tlb_canon #(.VA_W(VA_W), .IMPL_W(IMPL_W)) u_canon (.va(lk_va), .ok(va_ok));

  assign lk_go = lk_valid && va_ok;

  tlb_array #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (lk_va[IMPL_W-1:PG_W]),
    .lk_asn   (lk_asn),
    .hit_vec  (hit_vec),
    .hit_idx  (arr_idx),
    .rd_idx   (rd_idx),
    .rd_ppn   (rd_ppn),
    .ins_en   (ins_go),
    .ins_vpn  (ins_va[IMPL_W-1:PG_W]),
    .ins_asn  (ins_asn),
    .ins_glb  (ins_global),
    .ins_ppn  (ins_ppn),
    .victim   (victim),
    .fl_all   (fl_valid && (op == tlb_pkg::FL_ALL)),
    .fl_nonglb(fl_valid && (op == tlb_pkg::FL_NONGLB)),
    .fl_page  (fl_valid && (op == tlb_pkg::FL_PAGE)),
    .fl_vpn   (fl_va[IMPL_W-1:PG_W]),
    .fl_asn   (fl_asn)
  );

  tlb_mru #(.N(N), .DEPTH(DEPTH)) u_mru (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .sc_hit  (sc_hit),
    .sc_idx  (sc_idx),
    .clr     (fl_en),
    .push    (push),
    .push_idx(push_idx)
  );

  assign use_hit  = lk_go && (|hit_vec);
  assign rd_idx   = sc_hit ? sc_idx : arr_idx;
  assign push     = ins_go || use_hit;
  assign push_idx = ins_go ? victim : rd_idx;

  always_comb begin
    rv_d = lk_valid;
    rf_d = lk_valid && !va_ok;
    rh_d = use_hit;
    rp_d = use_hit ? rd_ppn : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_hit   <= rh_d;
      rsp_fault <= rf_d;
      rsp_ppn   <= rp_d;
    end
  end
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int N      = 8,
  parameter int VA_W   = 24,
  parameter int IMPL_W = 16,
  parameter int PPN_W  = 12,
  localparam int IW    = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_va,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic             fl_valid,
  input logic [1:0]       fl_op,
  input logic             ins_go,
  input logic             sc_hit,
  input logic [IW-1:0]    sc_idx,
  input logic [N-1:0]     hit_vec,
  input logic [IW-1:0]    victim
);
  logic upper_zero, upper_ones;
  assign upper_zero = (lk_va[VA_W-1:IMPL_W] == '0);
  assign upper_ones = (lk_va[VA_W-1:IMPL_W] == '1);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_fault);
  // R3
  miss_ppn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_ppn == '0);
  // R4
  noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !upper_zero && !upper_ones) |=> rsp_fault && !rsp_hit);
  // R4
  canon_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (upper_zero || upper_ones)) |=> !rsp_fault);
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> victim == (($past(victim) == IW'(N - 1)) ? '0 : $past(victim) + 1'b1));
  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_go |=> $stable(victim));
  // R10
  flush_drops_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_op != 2'd3) |-> !ins_go);
  // R6
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_op == 2'd0) |=> hit_vec == '0);
  // R12
  shortcut_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_hit |-> hit_vec[sc_idx]);
endmodule

bind asn_tlb asn_tlb_chk #(.N(N), .VA_W(VA_W), .IMPL_W(IMPL_W), .PPN_W(PPN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_va    (lk_va),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_fault(rsp_fault),
  .rsp_ppn  (rsp_ppn),
  .fl_valid (fl_valid),
  .fl_op    (fl_op),
  .ins_go   (ins_go),
  .sc_hit   (sc_hit),
  .sc_idx   (sc_idx),
  .hit_vec  (hit_vec),
  .victim   (victim)
);

// File: tb/asn_tlb_test.sv
module asn_tlb_test;
  localparam int N = 8;

  logic        clk, rst_n;
  logic        lk_valid, ins_valid, ins_global, fl_valid;
  logic [23:0] lk_va, ins_va, fl_va;
  logic [7:0]  lk_asn, ins_asn, fl_asn;
  logic [11:0] ins_ppn, rsp_ppn;
  logic [1:0]  fl_op;
  logic        rsp_valid, rsp_hit, rsp_fault;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic        m_vld [N];
  logic [7:0]  m_vpn [N];
  logic [7:0]  m_asn [N];
  logic        m_glb [N];
  logic [11:0] m_ppn [N];
  int          m_ptr;

  asn_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asn(lk_asn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
    .ins_valid(ins_valid), .ins_va(ins_va), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_ppn(ins_ppn),
    .fl_valid(fl_valid), .fl_op(fl_op), .fl_va(fl_va), .fl_asn(fl_asn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [23:0] mkva(input logic [7:0] up, input logic [7:0] vpn);
    return {up, vpn, 8'h5a};
  endfunction

  function automatic logic canon(input logic [23:0] va);
    return (va[23:16] == 8'h00) || (va[23:16] == 8'hff);
  endfunction

  function automatic logic m_match(input int i, input logic [7:0] vpn, input logic [7:0] asn);
    return m_vld[i] && (m_vpn[i] == vpn) && (m_glb[i] || (m_asn[i] == asn));
  endfunction

  function automatic logic clash(input logic [7:0] vpn, input logic [7:0] asn, input logic g);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == vpn && (g || m_glb[i] || m_asn[i] == asn)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_va = '0; lk_asn = '0;
    ins_valid = 0; ins_va = '0; ins_asn = '0; ins_global = 0; ins_ppn = '0;
    fl_valid = 0; fl_op = '0; fl_va = '0; fl_asn = '0;
  endtask

  task automatic step(input logic lv, input logic [23:0] la, input logic [7:0] las,
                      input logic iv, input logic [23:0] ia, input logic [7:0] ias,
                      input logic ig, input logic [11:0] ip,
                      input logic fv, input logic [1:0] fo, input logic [23:0] fa,
                      input logic [7:0] fas, input string tag);
    logic eh, ef;
    logic [11:0] ep;
    @(negedge clk);
    lk_valid = lv; lk_va = la; lk_asn = las;
    ins_valid = iv; ins_va = ia; ins_asn = ias; ins_global = ig; ins_ppn = ip;
    fl_valid = fv; fl_op = fo; fl_va = fa; fl_asn = fas;
    ef = lv && !canon(la);
    eh = 0; ep = '0;
    if (lv && !ef)
      for (int i = N - 1; i >= 0; i--)
        if (m_match(i, la[15:8], las)) begin eh = 1; ep = m_ppn[i]; end
    @(posedge clk);
    #1;
    check(rsp_valid == lv, {tag, " R2 rsp_valid"}, $sformatf("%0b", rsp_valid), $sformatf("%0b", lv));
    if (lv)
      check(rsp_hit == eh && rsp_fault == ef && rsp_ppn == ep, tag,
            $sformatf("hit=%0b fault=%0b ppn=%0h", rsp_hit, rsp_fault, rsp_ppn),
            $sformatf("hit=%0b fault=%0b ppn=%0h", eh, ef, ep));
    // model update: flush 0..2 wins over insert
    if (fv && fo != 2'd3) begin
      for (int i = 0; i < N; i++) begin
        if (fo == 2'd0) m_vld[i] = 0;
        else if (fo == 2'd1 && !m_glb[i]) m_vld[i] = 0;
        else if (fo == 2'd2 && m_match(i, fa[15:8], fas)) m_vld[i] = 0;
      end
    end else if (iv) begin
      m_vld[m_ptr] = 1; m_vpn[m_ptr] = ia[15:8]; m_asn[m_ptr] = ias;
      m_glb[m_ptr] = ig; m_ppn[m_ptr] = ip;
      m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    end
    idle_inputs();
  endtask

  task automatic look(input logic [23:0] va, input logic [7:0] asn, input string tag);
    step(1, va, asn, 0, '0, '0, 0, '0, 0, 2'd0, '0, '0, tag);
  endtask

  task automatic put(input logic [23:0] va, input logic [7:0] asn, input logic g,
                     input logic [11:0] ppn);
    step(0, '0, '0, 1, va, asn, g, ppn, 0, 2'd0, '0, '0, "insert");
  endtask

  task automatic flush(input logic [1:0] op, input logic [23:0] va, input logic [7:0] asn);
    step(0, '0, '0, 0, '0, '0, 0, '0, 1, op, va, asn, "flush");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_glb[i] = 0; m_ppn[i] = '0;
    end
    m_ptr = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset outputs
    check(!rsp_valid && !rsp_hit && !rsp_fault && rsp_ppn == 0, "R1 reset outputs",
          $sformatf("%0b%0b%0b %0h", rsp_valid, rsp_hit, rsp_fault, rsp_ppn), "000 0");
    @(negedge clk);
    rst_n = 1;
    look(mkva(8'h00, 8'h11), 8'd1, "R1 empty after reset");

    // R3 basic hit, asn mismatch, global
    put(mkva(8'h00, 8'h11), 8'd1, 0, 12'h0a1);
    look(mkva(8'h00, 8'h11), 8'd1, "R3 hit same asn");
    look(mkva(8'h00, 8'h11), 8'd2, "R3 miss other asn");
    look(mkva(8'h00, 8'h12), 8'd1, "R3 miss other vpn");
    put(mkva(8'h00, 8'h22), 8'd3, 1, 12'h0b2);
    look(mkva(8'h00, 8'h22), 8'd77, "R3 global any asn");

    // R4 canonical forms
    look(mkva(8'h12, 8'h11), 8'd1, "R4 non-canonical fault");
    look(mkva(8'h80, 8'h11), 8'd1, "R4 non-canonical top bit");
    look(mkva(8'hff, 8'h11), 8'd1, "R4 all-ones canonical hit");

    // R11 lookup concurrent with insert sees old contents
    step(1, mkva(8'h00, 8'h33), 8'd4, 1, mkva(8'h00, 8'h33), 8'd4, 0, 12'h0c3,
         0, 2'd0, '0, '0, "R11 same-cycle insert not visible");
    look(mkva(8'h00, 8'h33), 8'd4, "R11 visible next cycle");

    // R8 page flush, incl. global
    put(mkva(8'h00, 8'h44), 8'd4, 0, 12'h0d4);
    flush(2'd2, mkva(8'h00, 8'h33), 8'd4);
    look(mkva(8'h00, 8'h33), 8'd4, "R8 flushed page misses");
    look(mkva(8'h00, 8'h44), 8'd4, "R8 neighbour survives");
    flush(2'd2, mkva(8'h00, 8'h22), 8'd9);
    look(mkva(8'h00, 8'h22), 8'd3, "R8 global page flushed");

    // R7 non-global flush
    put(mkva(8'h00, 8'h55), 8'd0, 1, 12'h0e5);
    flush(2'd1, '0, '0);
    look(mkva(8'h00, 8'h55), 8'd6, "R7 global kept");
    look(mkva(8'h00, 8'h44), 8'd4, "R7 non-global gone");

    // R9 reserved flush with insert
    step(0, '0, '0, 1, mkva(8'h00, 8'h66), 8'd2, 0, 12'h0f6, 1, 2'd3, '0, '0, "R9");
    look(mkva(8'h00, 8'h55), 8'd6, "R9 reserved flush no effect");
    look(mkva(8'h00, 8'h66), 8'd2, "R9 insert beside reserved");

    // R10 flush beats insert
    step(0, '0, '0, 1, mkva(8'h00, 8'h77), 8'd2, 0, 12'h107, 1, 2'd2, mkva(8'h00, 8'h01),
         8'd0, "R10");
    look(mkva(8'h00, 8'h77), 8'd2, "R10 insert dropped by flush");

    // R6 flush all
    flush(2'd0, '0, '0);
    look(mkva(8'h00, 8'h55), 8'd6, "R6 flush all global gone");
    look(mkva(8'h00, 8'h66), 8'd2, "R6 flush all");

    // R5 replacement: N+2 inserts evict first two
    for (int k = 0; k < N + 2; k++) put(mkva(8'h00, 8'h40 + 8'(k)), 8'd5, 0, 12'h100 + 12'(k));
    for (int k = 0; k < N + 2; k++) look(mkva(8'h00, 8'h40 + 8'(k)), 8'd5, "R5 rotating replacement");
    check(!clash(8'h40, 8'd5, 0) && !clash(8'h41, 8'd5, 0), "R5 model evicted first two",
          "present", "evicted");

    // R12 random mix with hot keys
    for (int it = 0; it < 4000; it++) begin
      int r;
      logic lv, iv, fv, g;
      logic [7:0] lvpn, las, ivpn, ias, up;
      logic [1:0] fo;
      r = int'($urandom % 32);
      lvpn = 8'($urandom % 12); las = 8'($urandom % 3);
      ivpn = 8'($urandom % 12); ias = 8'($urandom % 3);
      g = ($urandom % 6) == 0;
      up = (($urandom % 10) == 0) ? 8'h3c : ((($urandom % 2) == 0) ? 8'h00 : 8'hff);
      lv = r < 26;
      iv = (r % 3) == 0 && !clash(ivpn, ias, g);
      fv = r >= 30;
      fo = 2'($urandom % 4);
      step(lv, mkva(up, lvpn), las, iv, mkva(8'h00, ivpn), ias, g, 12'($urandom),
           fv, fo, mkva(8'h00, 8'($urandom % 12)), 8'($urandom % 3), "R12 random vs model");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule